// File: doc/BRIEF.md
# Eight-Function 32-Bit Combinational ALU

This block is a purely combinational arithmetic-logic unit. Two 32-bit operands and a 3-bit function code go in, and one 32-bit result comes out. There is no clock, no storage and no status output. The result follows the present inputs only.

The eight functions form two groups. The arithmetic group covers add, increment, subtract, decrement and a 16x16 unsigned multiply. In that group, the low code bit replaces operand B with the constant 1. The upper two code bits choose the arithmetic unit. The logic group covers complement, XOR and a logical left shift of A by B.

All arithmetic wraps modulo 2^32. No carry, borrow or overflow indication is produced.

Top module: `alu8`

## Requirements
- R1: Code 000 gives R = (A + B) mod 2^32, so 0xFFFFFFFF + 0x00000001 gives 0.
- R2: Code 001 gives R = (A + 1) mod 2^32 for any B, so A = 0xFFFFFFFF gives 0.
- R3: Code 010 gives R = (A - B) mod 2^32, so 0 - 1 gives 0xFFFFFFFF.
- R4: Code 011 gives R = (A - 1) mod 2^32 for any B, so A = 0 gives 0xFFFFFFFF.
- R5: Code 100 gives R = A[15:0] * B[15:0] as an unsigned 32-bit product. Operand bits 31:16 have no effect, so 0xFFFF * 0xFFFF gives 0xFFFE0001.
- R6: Code 101 gives R = ~A, and B has no effect.
- R7: Code 110 gives R = A ^ B.
- R8: Code 111 gives R = A shifted left by B positions, with zeros filling the vacated low bits. B = 0 gives A, B = 31 moves A[0] into bit 31 and clears every other bit, and any B of 32 or more gives R = 0.
- R9: When the code's low bit is 1 and its top bit is 0, the second arithmetic operand is the constant 1 instead of B. The adder and the subtractor both use that same operand, so the value of B has no effect on codes 001 and 011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand (also the shift amount) |
| fn_i | input | 3 | Function code |
| r_o | output | 32 | Result |

## Verification
The hardest outcomes to reach from the ports are the edges of the shifter and of the multiplier. A shift amount whose set bits all lie above bit 4 must still clear the result, even though the low five bits alone would request no shift. The multiplier must ignore upper operand bits that random values rarely keep apart from the low half. The stimulus therefore adds directed vectors for these cases to a random sweep run under every code: shift amounts of 0, 31, 32 and 0x80000000, and multiply operands with FFFF in the low half and junk in the high half. It also sweeps every shift amount from 0 to 40 against several values of A.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned FN_W = 3;

  typedef enum logic [FN_W-1:0] {
    FN_ADD = 3'b000,
    FN_INC = 3'b001,
    FN_SUB = 3'b010,
    FN_DEC = 3'b011,
    FN_MUL = 3'b100,
    FN_NOT = 3'b101,
    FN_XOR = 3'b110,
    FN_SHL = 3'b111
  } alu_fn_e;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              use_one,
  output logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] sum,
  output logic [DATA_W-1:0] diff
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  function automatic logic [DATA_W-1:0] add_wrap(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] y);
    return x + y;
  endfunction

  // subtraction as addition of the two's complement
  function automatic logic [DATA_W-1:0] sub_wrap(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] y);
    return x + (~y) + ONE;
  endfunction

  assign opnd = use_one ? ONE : b;
  assign sum  = add_wrap(a, opnd);
  assign diff = sub_wrap(a, opnd);
endmodule

// File: rtl/alu8_mul.sv
module alu8_mul #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MUL_W  = 16
) (
  input  logic [MUL_W-1:0]  a,
  input  logic [MUL_W-1:0]  b,
  output logic [DATA_W-1:0] prod
);
  localparam int unsigned PROD_W = 2 * MUL_W;

  function automatic logic [PROD_W-1:0] umul(input logic [MUL_W-1:0] x,
                                             input logic [MUL_W-1:0] y);
    return PROD_W'(x) * PROD_W'(y);
  endfunction

  logic [PROD_W-1:0] full;
  assign full = umul(a, b);

  generate
    if (PROD_W >= DATA_W) begin : g_trunc
      assign prod = full[DATA_W-1:0];
    end else begin : g_ext
      assign prod = DATA_W'(full);
    end
  endgenerate
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] inv,
  output logic [DATA_W-1:0] xr,
  output logic [DATA_W-1:0] shl,
  output logic              shift_oob
);
  localparam int unsigned SHAMT_W = $clog2(DATA_W);

  assign inv = ~a;
  assign xr  = a ^ b;

  // any set bit above the shift-amount field means the shift is at least DATA_W
  assign shift_oob = |(b >> SHAMT_W);

  logic [DATA_W-1:0] stg [SHAMT_W+1];
  assign stg[0] = a;

  generate
    for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
      assign stg[k+1] = b[k] ? (stg[k] << (1 << k)) : stg[k];
    end
  endgenerate

  assign shl = shift_oob ? '0 : stg[SHAMT_W];
endmodule

// File: rtl/alu8.sv
module alu8 #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MUL_W  = 16
) (
  input  logic [DATA_W-1:0]          a_i,
  input  logic [DATA_W-1:0]          b_i,
  input  logic [alu8_pkg::FN_W-1:0]  fn_i,
  output logic [DATA_W-1:0]          r_o
);
  import alu8_pkg::*;

  alu_fn_e           fn;
  logic [DATA_W-1:0] arith_opnd, sum, diff, prod, inv, xr, shl;
  logic              shift_oob;

  assign fn = alu_fn_e'(fn_i);

  alu8_arith #(.DATA_W(DATA_W)) u_arith (
    .a(a_i), .b(b_i), .use_one(fn_i[0]),
    .opnd(arith_opnd), .sum(sum), .diff(diff)
  );

  alu8_mul #(.DATA_W(DATA_W), .MUL_W(MUL_W)) u_mul (
    .a(a_i[MUL_W-1:0]), .b(b_i[MUL_W-1:0]), .prod(prod)
  );

  alu8_logic #(.DATA_W(DATA_W)) u_logic (
    .a(a_i), .b(b_i), .inv(inv), .xr(xr), .shl(shl), .shift_oob(shift_oob)
  );

  always_comb begin
    r_o = '0;
    case (fn)
      FN_ADD, FN_INC: r_o = sum;
      FN_SUB, FN_DEC: r_o = diff;
      FN_MUL:         r_o = prod;
      FN_NOT:         r_o = inv;
      FN_XOR:         r_o = xr;
      FN_SHL:         r_o = shl;
      default:        r_o = '0;
    endcase
  end
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MUL_W  = 16
) (
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [2:0]        fn_i,
  input logic [DATA_W-1:0] r_o,
  input logic [DATA_W-1:0] arith_opnd,
  input logic              shift_oob
);
  always_comb begin
    // R9
    one_opnd_chk: assert (!(fn_i[2] == 1'b0 && fn_i[0] == 1'b1) || arith_opnd == DATA_W'(1))
      else $error("R9 arithmetic operand is not 1");
    // R1
    add_undo_chk: assert (fn_i != 3'b000 || (r_o - b_i) == a_i)
      else $error("R1 sum does not undo");
    // R2
    inc_undo_chk: assert (fn_i != 3'b001 || (r_o - DATA_W'(1)) == a_i)
      else $error("R2 increment does not undo");
    // R3
    sub_undo_chk: assert (fn_i != 3'b010 || (r_o + b_i) == a_i)
      else $error("R3 difference does not undo");
    // R4
    dec_undo_chk: assert (fn_i != 3'b011 || (r_o + DATA_W'(1)) == a_i)
      else $error("R4 decrement does not undo");
    // R5
    mul_zero_chk: assert (fn_i != 3'b100 || a_i[MUL_W-1:0] != '0 || r_o == '0)
      else $error("R5 product of zero low half is not zero");
    // R6
    not_cover_chk: assert (fn_i != 3'b101 || (r_o ^ a_i) == '1)
      else $error("R6 complement mismatch");
    // R7
    xor_undo_chk: assert (fn_i != 3'b110 || (r_o ^ b_i) == a_i)
      else $error("R7 xor does not undo");
    // R8
    shl_oob_chk: assert (fn_i != 3'b111 || !shift_oob || r_o == '0)
      else $error("R8 out-of-range shift not zero");
    // R8
    shl_none_chk: assert (fn_i != 3'b111 || shift_oob || b_i[4:0] != 5'd0 || r_o == a_i)
      else $error("R8 zero shift changed A");
  end
endmodule

bind alu8 alu8_chk #(.DATA_W(DATA_W), .MUL_W(MUL_W)) u_chk (
  .a_i(a_i), .b_i(b_i), .fn_i(fn_i), .r_o(r_o),
  .arith_opnd(arith_opnd), .shift_oob(shift_oob)
);

// File: tb/alu8_bench.sv
module alu8_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [31:0] a, b, r;
  logic [2:0]  fn;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;
  logic [31:0] lfsr  = 32'hACE1_2345;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8 u_alu8 (.a_i(a), .b_i(b), .fn_i(fn), .r_o(r));

  function automatic logic [31:0] ref_model(input logic [2:0] f,
                                            input logic [31:0] x,
                                            input logic [31:0] y);
    logic [32:0] wide;
    logic [31:0] acc;
    case (f)
      3'd0: begin wide = {1'b0, x} + {1'b0, y}; return wide[31:0]; end
      3'd1: begin wide = {1'b0, x} + 33'd1;      return wide[31:0]; end
      3'd2: return x - y;
      3'd3: return x - 32'd1;
      3'd4: begin
        acc = 0;
        for (int i = 0; i < 16; i++) if (y[i]) acc = acc + ({16'd0, x[15:0]} << i);
        return acc;
      end
      3'd5: return x ^ 32'hFFFF_FFFF;
      3'd6: return (x | y) & ~(x & y);
      default: begin
        acc = x;
        if (y > 32'd31) return 32'd0;
        for (int i = 0; i < 32; i++) if (i < y) acc = {acc[30:0], 1'b0};
        return acc;
      end
    endcase
  endfunction

  task automatic apply(input logic [2:0] f, input logic [31:0] x,
                       input logic [31:0] y, input logic [31:0] exp,
                       input string req);
    @(posedge clk);
    fn = f; a = x; b = y;
    @(negedge clk);
    n_cmp++;
    if (r !== exp) begin
      n_bad++;
      $display("FAIL %s fn=%0d a=%h b=%h actual=%h expected=%h", req, f, x, y, r, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] x, y;
    fn = 3'd0; a = 0; b = 0;
    // zero operands on every code
    apply(3'd0, 0, 0, 32'h0, "R1");
    apply(3'd1, 0, 0, 32'h1, "R2");
    apply(3'd2, 0, 0, 32'h0, "R3");
    apply(3'd3, 0, 0, 32'hFFFF_FFFF, "R4");
    apply(3'd4, 0, 0, 32'h0, "R5");
    apply(3'd5, 0, 0, 32'hFFFF_FFFF, "R6");
    apply(3'd6, 0, 0, 32'h0, "R7");
    apply(3'd7, 0, 0, 32'h0, "R8");
    // all-ones operands
    apply(3'd0, '1, '1, 32'hFFFF_FFFE, "R1");
    apply(3'd1, '1, '1, 32'h0, "R2");
    apply(3'd2, '1, '1, 32'h0, "R3");
    apply(3'd3, '1, '1, 32'hFFFF_FFFE, "R4");
    apply(3'd4, '1, '1, 32'hFFFE_0001, "R5");
    apply(3'd5, '1, '1, 32'h0, "R6");
    apply(3'd6, '1, '1, 32'h0, "R7");
    apply(3'd7, '1, '1, 32'h0, "R8");
    // wrap corners
    apply(3'd0, 32'hFFFF_FFFF, 32'd1, 32'h0, "R1");
    apply(3'd2, 32'd0, 32'd1, 32'hFFFF_FFFF, "R3");
    // multiply: upper halves ignored
    apply(3'd4, 32'h1234_FFFF, 32'hABCD_FFFF, 32'hFFFE_0001, "R5");
    apply(3'd4, 32'hFFFF_0000, 32'h0000_FFFF, 32'h0, "R5");
    // complement ignores B
    apply(3'd5, 32'h0F0F_1234, 32'hDEAD_BEEF, 32'hF0F0_EDCB, "R6");
    apply(3'd6, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0FF0_0FF0, "R7");
    // shift edges
    apply(3'd7, 32'h8765_4321, 32'd0, 32'h8765_4321, "R8");
    apply(3'd7, 32'h0000_0003, 32'd31, 32'h8000_0000, "R8");
    apply(3'd7, 32'hFFFF_FFFF, 32'd32, 32'h0, "R8");
    apply(3'd7, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0, "R8");
    apply(3'd7, 32'h0000_0001, 32'h0000_0020, 32'h0, "R8");
    // constant-one operand: B has no effect on 001 and 011
    apply(3'd1, 32'h7FFF_FFFF, 32'hDEAD_BEEF, 32'h8000_0000, "R9");
    apply(3'd3, 32'h8000_0000, 32'h1234_5678, 32'h7FFF_FFFF, "R9");
    // shift sweep
    for (int s = 0; s <= 40; s++) begin
      apply(3'd7, 32'hA5C3_0F91, s, ref_model(3'd7, 32'hA5C3_0F91, s), "R8");
      apply(3'd7, 32'h0000_0001, s, ref_model(3'd7, 32'h0000_0001, s), "R8");
    end
    // random sweep over every code
    for (int n = 0; n < 300; n++) begin
      step_lfsr(); x = lfsr;
      step_lfsr(); y = lfsr;
      apply(3'd0, x, y, ref_model(3'd0, x, y), "R1");
      apply(3'd1, x, y, ref_model(3'd1, x, y), "R2");
      apply(3'd2, x, y, ref_model(3'd2, x, y), "R3");
      apply(3'd3, x, y, ref_model(3'd3, x, y), "R4");
      apply(3'd4, x, y, ref_model(3'd4, x, y), "R5");
      apply(3'd5, x, y, ref_model(3'd5, x, y), "R6");
      apply(3'd6, x, y, ref_model(3'd6, x, y), "R7");
      apply(3'd7, x, {27'd0, y[4:0]}, ref_model(3'd7, x, {27'd0, y[4:0]}), "R8");
      apply(3'd1, x, ~y, ref_model(3'd1, x, 32'd0), "R9");
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule